// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address when the translation cache has missed. It reads two page table entries from main memory, one after the other. The first read comes from an outer table whose location is given by a table base value, which the address space context supplies. That entry points to an inner table, and the second read from the inner table yields the physical frame. A context switch therefore needs only a new base value. The 12-bit page offset is copied straight into the result.

A request carries the virtual address, a read/write flag and the table base. While the walk is running the walker raises `busy_o`. It finishes with a one-cycle `done_o` pulse. With that pulse it presents either the frame, the physical address and the leaf entry's flag bits, or a fault code. The memory side is a plain request/acknowledge port. The walker holds the request and its address until the memory acknowledges, and read data arrives in the same cycle as the acknowledge.

Top module: `pt_walker`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `busy_o`, `done_o` and `mem_req_o` are low.
- R2: A `start_i` seen while the walker is idle makes `busy_o` and `mem_req_o` high from the next cycle. The first address is base + p1×4, where p1 = vaddr[31:22].
- R3: Once `mem_req_o` is high it stays high, with `mem_addr_o` unchanged, until a cycle in which `mem_ack_i` is high. The read data is taken from `mem_rdata_i` in that same cycle.
- R4: After a valid outer entry, the second address is {outer[31:12], 12'h000} + p2×4, where p2 = vaddr[21:12].
- R5: A walk that succeeds gives `fault_o` = 0 and `frame_o` = inner[31:12]. It gives `paddr_o` = {inner[31:12], vaddr[11:0]}, and `perm_o` = inner[2:0], where bit 0 is valid, bit 1 is writable and bit 2 is dirty.
- R6: If the outer entry has bit 0 clear, the walk ends with `fault_o` = 1 after exactly one memory read. `frame_o` and `paddr_o` are zero in that case.
- R7: If the inner entry has bit 0 clear, the walk ends with `fault_o` = 2.
- R8: A write walk whose valid inner entry has bit 1 clear ends with `fault_o` = 3. A read walk to the same entry succeeds.
- R9: An invalid inner entry reports `fault_o` = 2 even on a write to an entry that is not writable.
- R10: During a walk, `start_i`, `vaddr_i`, `is_write_i` and `base_i` are ignored. The result comes only from the values captured when the walk was accepted.
- R11: `busy_o` stays high in every cycle from acceptance up to the `done_o` cycle, and it is low in that cycle. `done_o` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| vaddr_i | input | 32 | Virtual address to translate |
| is_write_i | input | 1 | Access is a write |
| base_i | input | 32 | Outer table base address |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ack_i | input | 1 | Memory acknowledge, data valid |
| mem_rdata_i | input | 32 | Memory read data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 2 | 0 none, 1 outer invalid, 2 inner invalid, 3 write protection |
| frame_o | output | 20 | Translated frame number |
| paddr_o | output | 32 | Translated physical address |
| perm_o | output | 3 | Leaf flags {dirty, writable, valid} |

## Verification
The walker is driven with several kinds of walk. There are clean reads with no memory wait, and writes to writable, dirty pages with a memory that stalls; the stalled case separates correct request holding from an address that drifts. Invalid outer entries and invalid inner entries tell the two page-fault codes apart and show whether the inner read is skipped. Write and read walks to a read-only leaf, and a leaf that is both invalid and read-only, separate the protection check from the validity check and show their priority. A walk disturbed by a second start, a new address and a new base in mid-flight shows whether the context is captured only at acceptance.

// File: rtl/pt_walk_pkg.sv
// Package: shared widths, entry layout, walker states and fault codes.
// Assumes 4 KB pages and 4-byte table entries.
package pt_walk_pkg;
    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int FRAME_W   = VA_W - OFF_W;
    localparam int IDX_W     = FRAME_W / 2;
    localparam int FLG_VALID = 0;
    localparam int FLG_WRITE = 1;
    localparam int FLG_DIRTY = 2;
    localparam int FLG_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OUTER,
        ST_INNER,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE       = 2'd0,
        FLT_OUTER_INV  = 2'd1,
        FLT_INNER_INV  = 2'd2,
        FLT_WRITE_PROT = 2'd3
    } fault_e;
endpackage

// File: rtl/pt_walk_addr.sv
// Module: forms the table entry address for the current level.
// Assumes entries are 2**ENTRY_SHIFT bytes; the inner table is page aligned.
module pt_walk_addr #(
    parameter int VA_W        = 32,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_SHIFT = 2,
    localparam int FRAME_W    = VA_W - OFF_W
) (
    input  logic               sel_inner,
    input  logic [VA_W-1:0]    outer_base,
    input  logic [FRAME_W-1:0] inner_frame,
    input  logic [IDX_W-1:0]   idx_outer,
    input  logic [IDX_W-1:0]   idx_inner,
    output logic [VA_W-1:0]    entry_addr
);
    logic [VA_W-1:0]  table_base;
    logic [IDX_W-1:0] index;

    // Pick table base and index for the level, then scale the index.
    always_comb begin
        table_base = sel_inner ? {inner_frame, {OFF_W{1'b0}}} : outer_base;
        index      = sel_inner ? idx_inner : idx_outer;
        entry_addr = table_base + (VA_W'(index) << ENTRY_SHIFT);
    end
endmodule

// File: rtl/pt_walk_check.sv
// Module: classifies a fetched entry into a fault code.
// Assumes only the leaf entry is checked for write permission;
// validity outranks protection.
module pt_walk_check
    import pt_walk_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0] entry,
    input  logic            is_leaf,
    input  logic            is_write,
    output fault_e          fault
);
    // Validity first, then the write permission of the leaf.
    always_comb begin
        if (!entry[FLG_VALID]) begin
            fault = is_leaf ? FLT_INNER_INV : FLT_OUTER_INV;
        end else if (is_leaf && is_write && !entry[FLG_WRITE]) begin
            fault = FLT_WRITE_PROT;
        end else begin
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/pt_walk_fsm.sv
// Module: walk sequencer IDLE -> OUTER -> INNER -> DONE, or FAULT.
// Assumes each read level ends on the cycle mem_ack is high.
module pt_walk_fsm
    import pt_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mem_ack,
    input  fault_e      entry_fault,
    output walk_state_e state
);
    walk_state_e nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_OUTER;
            ST_OUTER: if (mem_ack) nxt = (entry_fault == FLT_NONE) ? ST_INNER : ST_FAULT;
            ST_INNER: if (mem_ack) nxt = (entry_fault == FLT_NONE) ? ST_DONE : ST_FAULT;
            ST_DONE:  nxt = ST_IDLE;
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/pt_walker.sv
// Module: two-level page table walker top.
// Assumes a memory that keeps read data valid with ack and accepts a
// held request; results stay on the outputs until the next walk ends.
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int VA_W        = pt_walk_pkg::VA_W,
    parameter int OFF_W       = pt_walk_pkg::OFF_W,
    parameter int ENTRY_SHIFT = 2,
    localparam int FRAME_W    = VA_W - OFF_W,
    localparam int IDX_W      = FRAME_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [VA_W-1:0]    vaddr_i,
    input  logic               is_write_i,
    input  logic [VA_W-1:0]    base_i,
    output logic               mem_req_o,
    output logic [VA_W-1:0]    mem_addr_o,
    input  logic               mem_ack_i,
    input  logic [VA_W-1:0]    mem_rdata_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [1:0]         fault_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic [VA_W-1:0]    paddr_o,
    output logic [FLG_W-1:0]   perm_o
);
    walk_state_e        state;
    fault_e             entry_fault;
    logic [VA_W-1:0]    va_q;
    logic [VA_W-1:0]    base_q;
    logic               wr_q;
    logic [FRAME_W-1:0] inner_tab_q;
    logic [FRAME_W-1:0] frame_q;
    logic [FLG_W-1:0]   flags_q;
    fault_e             fault_q;
    logic               accept;
    logic               leaf;

    assign accept = (state == ST_IDLE) && start_i;
    assign leaf   = (state == ST_INNER);

    pt_walk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_i),
        .mem_ack     (mem_ack_i),
        .entry_fault (entry_fault),
        .state       (state)
    );

    pt_walk_addr #(
        .VA_W        (VA_W),
        .OFF_W       (OFF_W),
        .IDX_W       (IDX_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_addr (
        .sel_inner   (leaf),
        .outer_base  (base_q),
        .inner_frame (inner_tab_q),
        .idx_outer   (va_q[VA_W-1 -: IDX_W]),
        .idx_inner   (va_q[OFF_W +: IDX_W]),
        .entry_addr  (mem_addr_o)
    );

    pt_walk_check #(
        .VA_W (VA_W)
    ) u_check (
        .entry    (mem_rdata_i),
        .is_leaf  (leaf),
        .is_write (wr_q),
        .fault    (entry_fault)
    );

    // Capture the walk context when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            base_q <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            va_q   <= vaddr_i;
            base_q <= base_i;
            wr_q   <= is_write_i;
        end
    end

    // Keep the inner table frame from an acknowledged outer read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inner_tab_q <= '0;
        end else if (state == ST_OUTER && mem_ack_i) begin
            inner_tab_q <= mem_rdata_i[VA_W-1 -: FRAME_W];
        end
    end

    // Record the result when a level ends the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            flags_q <= '0;
            fault_q <= FLT_NONE;
        end else if (mem_ack_i && (leaf || (state == ST_OUTER && entry_fault != FLT_NONE))) begin
            fault_q <= entry_fault;
            flags_q <= mem_rdata_i[FLG_W-1:0];
            frame_q <= (leaf && entry_fault == FLT_NONE) ? mem_rdata_i[VA_W-1 -: FRAME_W] : '0;
        end
    end

    // Drive the handshake and result outputs.
    always_comb begin
        busy_o    = (state == ST_OUTER) || (state == ST_INNER);
        done_o    = (state == ST_DONE) || (state == ST_FAULT);
        mem_req_o = busy_o;
        fault_o   = fault_q;
        frame_o   = frame_q;
        perm_o    = flags_q;
        paddr_o   = (fault_q == FLT_NONE) ? {frame_q, va_q[OFF_W-1:0]} : '0;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Module: protocol and result properties of the walker, bound into it.
// Assumes the default entry layout (bit 0 valid).
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        mem_req_o,
    input logic        mem_ack_i,
    input logic [31:0] mem_addr_o,
    input logic [1:0]  fault_o,
    input logic [2:0]  perm_o,
    input logic        wr_q
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !busy_o && !done_o && !mem_req_o);

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && !done_o |=> busy_o && mem_req_o);

    p_req_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

    p_ok_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && fault_o == 2'd0 |-> perm_o[0]);

    p_prot_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && fault_o == 2'd3 |-> wr_q && perm_o[0] && !perm_o[1]);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_req_o  (mem_req_o),
    .mem_ack_i  (mem_ack_i),
    .mem_addr_o (mem_addr_o),
    .fault_o    (fault_o),
    .perm_o     (perm_o),
    .wr_q       (wr_q)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic        is_write_i = 1'b0;
    logic [31:0] base_i = '0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        busy_o, done_o;
    logic [1:0]  fault_o;
    logic [19:0] frame_o;
    logic [31:0] paddr_o;
    logic [2:0]  perm_o;

    int n_checks = 0;
    int n_fail = 0;
    int lat = 0;
    int wait_cnt = 0;
    int req_cnt = 0;
    bit hold_bad = 0;
    logic [31:0] held_addr;
    logic [31:0] addr_log [2];
    logic [31:0] mem [logic [31:0]];

    // result capture
    logic [19:0] r_frame;
    logic [31:0] r_paddr;
    logic [2:0]  r_perm;
    logic [1:0]  r_fault;
    bit          r_busy_bad;

    always #4 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
        .is_write_i(is_write_i), .base_i(base_i), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .frame_o(frame_o),
        .paddr_o(paddr_o), .perm_o(perm_o)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Behavioural memory: acks after lat waiting cycles, checks address hold.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack_i) begin
                mem_ack_i = 1'b0;
                wait_cnt = 0;
            end else if (mem_req_o) begin
                if (wait_cnt == 0) held_addr = mem_addr_o;
                else if (mem_addr_o !== held_addr) hold_bad = 1;
                if (wait_cnt >= lat) begin
                    mem_ack_i = 1'b1;
                    mem_rdata_i = rd(mem_addr_o);
                    if (req_cnt < 2) addr_log[req_cnt] = mem_addr_o;
                    req_cnt++;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] outer_addr(input logic [31:0] b, input logic [31:0] va);
        return b + {20'd0, va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] inner_addr(input logic [19:0] t, input logic [31:0] va);
        return {t, 12'h000} + {20'd0, va[21:12], 2'b00};
    endfunction

    // Fill both table levels for one virtual page.
    task automatic map(input logic [31:0] b, input logic [31:0] va, input logic [2:0] oflg,
                       input logic [19:0] itab, input logic [19:0] frm, input logic [2:0] iflg);
        mem[outer_addr(b, va)] = {itab, 9'd0, oflg};
        mem[inner_addr(itab, va)] = {frm, 9'd0, iflg};
    endtask

    // Run one walk; optionally disturb the inputs one cycle after acceptance.
    task automatic walk(input logic [31:0] b, input logic [31:0] va, input bit wr,
                        input bit disturb);
        int cyc;
        @(negedge clk);
        base_i = b; vaddr_i = va; is_write_i = wr; start_i = 1'b1;
        req_cnt = 0; hold_bad = 0; r_busy_bad = 0;
        addr_log[0] = 'x; addr_log[1] = 'x;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 500) begin
            if (!busy_o) r_busy_bad = 1;
            if (disturb && cyc == 1) begin
                start_i = 1'b1; vaddr_i = ~va; base_i = b + 32'h0010_0000; is_write_i = ~wr;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        if (!done_o) begin
            n_fail++;
            $display("FAIL R11: actual no done expected done within 500 cycles");
        end
        r_frame = frame_o; r_paddr = paddr_o; r_perm = perm_o; r_fault = fault_o;
        chk("R11 busy low in done cycle", {31'd0, busy_o}, 32'd0);
        chk("R11 busy held during walk", {31'd0, r_busy_bad}, 32'd0);
        @(negedge clk);
        chk("R11 done one cycle", {31'd0, done_o}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 busy in reset", {31'd0, busy_o}, 32'd0);
        chk("R1 done in reset", {31'd0, done_o}, 32'd0);
        chk("R1 req in reset", {31'd0, mem_req_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", {31'd0, busy_o}, 32'd0);
        chk("R1 req after reset", {31'd0, mem_req_o}, 32'd0);
    endtask

    task automatic t_read_ok;
        logic [31:0] b = 32'h0004_0000, va = 32'h8034_5ABC;
        lat = 0;
        map(b, va, 3'b001, 20'h00123, 20'hABCDE, 3'b011);
        walk(b, va, 1'b0, 1'b0);
        chk("R2 outer address", addr_log[0], outer_addr(b, va));
        chk("R4 inner address", addr_log[1], inner_addr(20'h00123, va));
        chk("R5 fault", {30'd0, r_fault}, 32'd0);
        chk("R5 frame", {12'd0, r_frame}, {12'd0, 20'hABCDE});
        chk("R5 paddr", r_paddr, {20'hABCDE, va[11:0]});
        chk("R5 perm", {29'd0, r_perm}, 32'd3);
    endtask

    task automatic t_write_stall;
        logic [31:0] b = 32'h0010_0100, va = 32'h0FFF_F001;
        lat = 3;
        map(b, va, 3'b011, 20'h00777, 20'h12345, 3'b111);
        walk(b, va, 1'b1, 1'b0);
        chk("R3 address held while stalled", {31'd0, hold_bad}, 32'd0);
        chk("R3 two reads", req_cnt, 32'd2);
        chk("R4 inner address stalled", addr_log[1], inner_addr(20'h00777, va));
        chk("R5 write ok fault", {30'd0, r_fault}, 32'd0);
        chk("R5 dirty perm", {29'd0, r_perm}, 32'd7);
        chk("R5 write paddr", r_paddr, {20'h12345, va[11:0]});
    endtask

    task automatic t_outer_invalid;
        logic [31:0] b = 32'h0020_0000, va = 32'h4000_1234;
        lat = 1;
        mem[outer_addr(b, va)] = {20'h00999, 9'd0, 3'b010};
        mem[inner_addr(20'h00999, va)] = {20'h55555, 9'd0, 3'b011};
        walk(b, va, 1'b0, 1'b0);
        chk("R6 fault code", {30'd0, r_fault}, 32'd1);
        chk("R6 single read", req_cnt, 32'd1);
        chk("R6 frame zero", {12'd0, r_frame}, 32'd0);
        chk("R6 paddr zero", r_paddr, 32'd0);
    endtask

    task automatic t_inner_invalid;
        logic [31:0] b = 32'h0030_0000, va = 32'h0040_2000;
        lat = 0;
        map(b, va, 3'b001, 20'h00444, 20'h0AAAA, 3'b110);
        walk(b, va, 1'b0, 1'b0);
        chk("R7 fault code", {30'd0, r_fault}, 32'd2);
        chk("R7 two reads", req_cnt, 32'd2);
    endtask

    task automatic t_protect;
        logic [31:0] b = 32'h0050_0000, va = 32'hC000_3FFF;
        lat = 2;
        map(b, va, 3'b001, 20'h00321, 20'h0BEEF, 3'b001);
        walk(b, va, 1'b1, 1'b0);
        chk("R8 write to read-only", {30'd0, r_fault}, 32'd3);
        walk(b, va, 1'b0, 1'b0);
        chk("R8 read of read-only", {30'd0, r_fault}, 32'd0);
        chk("R8 read frame", {12'd0, r_frame}, {12'd0, 20'h0BEEF});
    endtask

    task automatic t_priority;
        logic [31:0] b = 32'h0060_0000, va = 32'h1234_5678;
        lat = 0;
        map(b, va, 3'b001, 20'h00654, 20'h0CAFE, 3'b000);
        walk(b, va, 1'b1, 1'b0);
        chk("R9 invalid before protection", {30'd0, r_fault}, 32'd2);
    endtask

    task automatic t_disturb;
        logic [31:0] b = 32'h0070_0000, va = 32'h2468_ACE0;
        lat = 2;
        map(b, va, 3'b001, 20'h00888, 20'h13579, 3'b001);
        mem[outer_addr(b + 32'h0010_0000, ~va)] = {20'h00999, 9'd0, 3'b001};
        mem[inner_addr(20'h00999, ~va)] = {20'h0DEAD, 9'd0, 3'b011};
        walk(b, va, 1'b0, 1'b1);
        chk("R10 frame from captured context", {12'd0, r_frame}, {12'd0, 20'h13579});
        chk("R10 no fault from changed write flag", {30'd0, r_fault}, 32'd0);
        chk("R10 outer address from captured base", addr_log[0], outer_addr(b, va));
        chk("R10 paddr offset captured", r_paddr, {20'h13579, va[11:0]});
        chk("R10 two reads only", req_cnt, 32'd2);
        @(negedge clk);
        chk("R10 still idle after", {31'd0, busy_o}, 32'd0);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        t_read_ok();
        t_write_stall();
        t_outer_invalid();
        t_inner_invalid();
        t_protect();
        t_priority();
        t_disturb();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule